// File: doc/BRIEF.md
# Tone Transceiver Host Register Interface

This block is the host-side register file of a dual-tone signalling transceiver. A small processor reaches it over a 4-bit data bus with one register-select line and single-cycle read and write strobes. The register reached depends on both the select line and the direction of access. With the select line low, a read returns the last received digit and a write loads the digit to transmit. With the select line high, a read returns status and a write goes to one of two control registers.

The tone detector and tone generator sit outside the block and are seen only through simple handshake signals. The detector sends a pulse with a 4-bit digit code. The generator reports a one-cycle done pulse when a burst ends. A steering level comes in from the detector as well. On its side the block drives the digit to generate, a load pulse, and the control fields. It raises an active-low interrupt when a new digit is latched, or when a burst drains the transmit register. Reading status clears the pending flags.

Three small state machines hold the behaviour:
- Control-pointer machine. State CP_TO_A moves to CP_TO_B on a control write with bit 3 set. CP_TO_B always returns to CP_TO_A on the next control write.
- Receive machine. RX_EMPTY moves to RX_HOLD on a digit pulse. RX_HOLD returns to RX_EMPTY on any read, unless a digit pulse arrives in the same cycle.
- Transmit machine. TX_IDLE moves to TX_PEND on a transmit write. TX_PEND returns to TX_IDLE on a done pulse, unless a write arrives in the same cycle.

A fourth machine in the top level tracks the interrupt. IRQ_IDLE moves to IRQ_PEND on an enabled event. IRQ_PEND returns to IRQ_IDLE on a status read, unless an enabled event arrives in the same cycle.

Top module: `dtx_host_regs`

## Requirements
- R1: After reset, all control fields are 0, the control pointer selects control A, the received-digit and transmit-digit registers hold 0, tx_load is 0, irq_n is 1, and status reads 0 in bits 0 to 2.
- R2: A det_valid pulse latches det_code. A read with sel=0 returns that code on rdata in the cycle of the strobe. Status bit 2 (receive full) reads 1 from the next cycle on.
- R3: A read with sel=0 clears receive full and leaves the received digit unchanged. It does not clear the interrupt flag.
- R4: A read with sel=1 returns the status register in the strobe cycle, then clears the interrupt flag and receive full. The status bits are:
    - bit 0: interrupt pending
    - bit 1: transmit empty
    - bit 2: receive full
    - bit 3: the steer_lvl input
- R5: A write with sel=0 places wdata on tx_code one cycle later. It also gives a one-cycle tx_load pulse in that cycle, but only if control A bit 0 was 1 at the write.
- R6: The control A fields are:
    - bit 0: tone_on
    - bit 1: cp_mode
    - bit 2: interrupt enable
    - bit 3: send the next control write to control B
  In control B, bit 0 is burst_en and bits 3:1 drive aux_ctl[2:0]. After a write to control B, the next control write goes to control A again. A control A write with bit 3 clear keeps the pointer on control A.
- R7: Status bit 1 reads 1 only when burst_en is 1 and no transmit digit is outstanding. It reads 0 from the cycle after a transmit write until the cycle after tx_done.
- R8: With interrupt enable set, irq_n goes low one cycle after a det_valid pulse, or after a tx_done that completes a burst. It stays low until a status read. With interrupt enable clear, these events leave irq_n high and status bit 0 at 0.
- R9: When an event and a clear fall in the same cycle, the event wins:
    - det_valid with any read leaves receive full set.
    - An enabled event with a status read leaves the interrupt pending.
    - The read in that cycle returns the values held before the edge.
- R10: rdata is 0 in every cycle without a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 1 | Register select |
| rd_stb | input | 1 | One-cycle read strobe |
| wr_stb | input | 1 | One-cycle write strobe |
| wdata | input | DW | Host write data |
| rdata | output | DW | Host read data, valid in the strobe cycle |
| det_valid | input | 1 | Digit-detected pulse from tone detector |
| det_code | input | DW | Detected digit code |
| steer_lvl | input | 1 | Delayed steering level from detector |
| tx_done | input | 1 | Burst-complete pulse from tone generator |
| tx_code | output | DW | Digit to generate |
| tx_load | output | 1 | One-cycle load pulse to tone generator |
| tone_on | output | 1 | Tone output enable |
| cp_mode | output | 1 | Call-progress mode select |
| burst_en | output | 1 | Burst mode enable |
| aux_ctl | output | DW-1 | Remaining control B fields |
| irq_n | output | 1 | Active-low interrupt |

## Verification
A status read that clears the flags can fall in the same cycle as a det_valid pulse or a burst-completing tx_done that sets them. This is the collision that matters most. The bench drives the strobe and the event in one cycle on purpose. It checks that the read returns the flags as they stood before the edge, and that irq_n and receive full are still asserted afterwards. A long run of random bus and event traffic then repeats this collision, and others like it, against a behavioural model that is compared every cycle.

// File: rtl/dtx_pkg.sv
package dtx_pkg;
    localparam int DTX_DW = 4;

    // fixed status and control bit positions (host software decodes them)
    localparam int ST_IRQ    = 0;
    localparam int ST_TXE    = 1;
    localparam int ST_RXF    = 2;
    localparam int ST_STEER  = 3;
    localparam int CA_TONE   = 0;
    localparam int CA_CPM    = 1;
    localparam int CA_IRQEN  = 2;
    localparam int CA_BANK   = 3;
    localparam int CB_BURST  = 0;

    typedef enum logic { CP_TO_A, CP_TO_B }  ctl_ptr_e;
    typedef enum logic { RX_EMPTY, RX_HOLD } rx_st_e;
    typedef enum logic { TX_IDLE, TX_PEND }  tx_st_e;
    typedef enum logic { IRQ_IDLE, IRQ_PEND } irq_st_e;
endpackage

// File: rtl/dtx_ctl_seq.sv
module dtx_ctl_seq
    import dtx_pkg::*;
#(
    parameter int DW = DTX_DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctl_wr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] ctl_a,
    output logic [DW-1:0] ctl_b
);
    ctl_ptr_e state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CP_TO_A;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        if (ctl_wr) begin
            unique case (state_q)
                CP_TO_A: if (wdata[CA_BANK]) state_d = CP_TO_B;
                CP_TO_B: state_d = CP_TO_A;
            endcase
        end
    end

    // outputs: the register addressed by the current pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_a <= '0;
            ctl_b <= '0;
        end else if (ctl_wr) begin
            if (state_q == CP_TO_A) ctl_a <= wdata;
            else                    ctl_b <= wdata;
        end
    end
endmodule

// File: rtl/dtx_rx_latch.sv
module dtx_rx_latch
    import dtx_pkg::*;
#(
    parameter int DW = DTX_DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          det_valid,
    input  logic [DW-1:0] det_code,
    input  logic          clr,
    output logic [DW-1:0] rx_data,
    output logic          rx_full
);
    rx_st_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RX_EMPTY;
        else        state_q <= state_d;
    end

    // a new digit beats a same-cycle clear
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_EMPTY: if (det_valid)         state_d = RX_HOLD;
            RX_HOLD:  if (clr && !det_valid) state_d = RX_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)         rx_data <= '0;
        else if (det_valid) rx_data <= det_code;
    end

    assign rx_full = (state_q == RX_HOLD);
endmodule

// File: rtl/dtx_tx_track.sv
module dtx_tx_track
    import dtx_pkg::*;
#(
    parameter int DW = DTX_DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tx_wr,
    input  logic [DW-1:0] wdata,
    input  logic          tone_on,
    input  logic          burst_en,
    input  logic          tx_done,
    output logic [DW-1:0] tx_code,
    output logic          tx_load,
    output logic          tx_empty,
    output logic          tx_event
);
    tx_st_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TX_IDLE;
        else        state_q <= state_d;
    end

    // a new write keeps the register occupied even if a burst ends now
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE: if (tx_wr) state_d = TX_PEND;
            TX_PEND: begin
                if (tx_wr)        state_d = TX_PEND;
                else if (tx_done) state_d = TX_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_code <= '0;
            tx_load <= 1'b0;
        end else begin
            tx_load <= tx_wr && tone_on;
            if (tx_wr) tx_code <= wdata;
        end
    end

    assign tx_empty = (state_q == TX_IDLE);
    assign tx_event = tx_done && (state_q == TX_PEND) && burst_en;
endmodule

// File: rtl/dtx_host_regs.sv
module dtx_host_regs
    import dtx_pkg::*;
#(
    parameter int DW = DTX_DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel,
    input  logic          rd_stb,
    input  logic          wr_stb,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    input  logic          det_valid,
    input  logic [DW-1:0] det_code,
    input  logic          steer_lvl,
    input  logic          tx_done,
    output logic [DW-1:0] tx_code,
    output logic          tx_load,
    output logic          tone_on,
    output logic          cp_mode,
    output logic          burst_en,
    output logic [DW-2:0] aux_ctl,
    output logic          irq_n
);
    logic [DW-1:0] ctl_a, ctl_b, rx_data, stat_v;
    logic          rx_full, tx_empty, tx_event, irq_en, stat_rd;
    irq_st_e       irq_q, irq_d;

    assign stat_rd = rd_stb && sel;

    dtx_ctl_seq #(.DW(DW)) u_ctl (
        .clk(clk), .rst_n(rst_n), .ctl_wr(wr_stb && sel), .wdata(wdata),
        .ctl_a(ctl_a), .ctl_b(ctl_b)
    );

    dtx_rx_latch #(.DW(DW)) u_rx (
        .clk(clk), .rst_n(rst_n), .det_valid(det_valid), .det_code(det_code),
        .clr(rd_stb), .rx_data(rx_data), .rx_full(rx_full)
    );

    dtx_tx_track #(.DW(DW)) u_tx (
        .clk(clk), .rst_n(rst_n), .tx_wr(wr_stb && !sel), .wdata(wdata),
        .tone_on(tone_on), .burst_en(burst_en), .tx_done(tx_done),
        .tx_code(tx_code), .tx_load(tx_load), .tx_empty(tx_empty),
        .tx_event(tx_event)
    );

    assign tone_on  = ctl_a[CA_TONE];
    assign cp_mode  = ctl_a[CA_CPM];
    assign irq_en   = ctl_a[CA_IRQEN];
    assign burst_en = ctl_b[CB_BURST];
    assign aux_ctl  = ctl_b[DW-1:1];

    // interrupt state machine
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= IRQ_IDLE;
        else        irq_q <= irq_d;
    end

    always_comb begin
        irq_d = irq_q;
        unique case (irq_q)
            IRQ_IDLE: if (irq_en && (det_valid || tx_event)) irq_d = IRQ_PEND;
            IRQ_PEND: if (stat_rd && !(irq_en && (det_valid || tx_event)))
                          irq_d = IRQ_IDLE;
        endcase
    end

    assign irq_n = (irq_q != IRQ_PEND);

    // read path
    always_comb begin
        stat_v           = '0;
        stat_v[ST_IRQ]   = (irq_q == IRQ_PEND);
        stat_v[ST_TXE]   = burst_en && tx_empty;
        stat_v[ST_RXF]   = rx_full;
        stat_v[ST_STEER] = steer_lvl;
    end

    always_comb begin
        if (!rd_stb)  rdata = '0;
        else if (sel) rdata = stat_v;
        else          rdata = rx_data;
    end
endmodule

// File: rtl/dtx_host_regs_chk.sv
module dtx_host_regs_chk #(
    parameter int DW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sel,
    input logic          rd_stb,
    input logic          wr_stb,
    input logic          det_valid,
    input logic          tx_done,
    input logic          rx_full,
    input logic          irq_en,
    input logic          tone_on,
    input logic          tx_load,
    input logic          irq_n,
    input logic [DW-1:0] rdata
);
    AST_RX_FULL_SET: assert property (@(posedge clk) disable iff (!rst_n)
        det_valid |=> rx_full);                                            // R2
    AST_RX_RD_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !sel && !det_valid) |=> !rx_full);                      // R3
    AST_STAT_CLR_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && sel && !det_valid && !tx_done) |=> irq_n);              // R4
    AST_LOAD_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load |-> $past(wr_stb && !sel && tone_on));                     // R5
    AST_IRQ_ON_DIGIT: assert property (@(posedge clk) disable iff (!rst_n)
        (det_valid && irq_en) |=> !irq_n);                                 // R8
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_n && !(rd_stb && sel)) |=> !irq_n);                          // R8
    AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |-> (rdata == '0));                                        // R10
endmodule

bind dtx_host_regs dtx_host_regs_chk #(.DW(DW)) chk_i (
    .clk(clk), .rst_n(rst_n), .sel(sel), .rd_stb(rd_stb), .wr_stb(wr_stb),
    .det_valid(det_valid), .tx_done(tx_done), .rx_full(rx_full),
    .irq_en(irq_en), .tone_on(tone_on), .tx_load(tx_load), .irq_n(irq_n),
    .rdata(rdata)
);

// File: tb/dtx_host_regs_tb.sv
module dtx_host_regs_tb_top;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel = 1'b0, rd_stb = 1'b0, wr_stb = 1'b0;
    logic [3:0] wdata = '0, det_code = '0;
    logic       det_valid = 1'b0, steer_lvl = 1'b0, tx_done = 1'b0;
    logic [3:0] rdata, tx_code;
    logic [2:0] aux_ctl;
    logic       tx_load, tone_on, cp_mode, burst_en, irq_n;

    int n_chk = 0;
    int n_bad = 0;

    // behavioural model state
    logic [3:0] m_ca = '0, m_cb = '0, m_rxd = '0, m_txc = '0;
    bit         m_ptrb = 0, m_rxf = 0, m_txpend = 0, m_txl = 0, m_irq = 0;

    always #(CLK_P/2) clk = ~clk;

    dtx_host_regs dut_i (
        .clk(clk), .rst_n(rst_n), .sel(sel), .rd_stb(rd_stb), .wr_stb(wr_stb),
        .wdata(wdata), .rdata(rdata), .det_valid(det_valid), .det_code(det_code),
        .steer_lvl(steer_lvl), .tx_done(tx_done), .tx_code(tx_code),
        .tx_load(tx_load), .tone_on(tone_on), .cp_mode(cp_mode),
        .burst_en(burst_en), .aux_ctl(aux_ctl), .irq_n(irq_n)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic chk_regs();
        chk("R5", "tx_code", tx_code, m_txc);
        chk("R5", "tx_load", tx_load, m_txl);
        chk("R6", "tone_on", tone_on, m_ca[0]);
        chk("R6", "cp_mode", cp_mode, m_ca[1]);
        chk("R6", "burst_en", burst_en, m_cb[0]);
        chk("R6", "aux_ctl", aux_ctl, m_cb[3:1]);
        chk("R8", "irq_n", irq_n, !m_irq);
    endtask

    // one bus cycle: check registered outputs, drive, check rdata, advance model
    task automatic step(input bit s, input bit r, input bit w, input logic [3:0] wd,
                        input bit dv, input logic [3:0] dc, input bit sl, input bit td,
                        input string tag);
        logic [3:0] exp_rd;
        bit ev;
        @(negedge clk);
        chk_regs();
        sel = s; rd_stb = r; wr_stb = w; wdata = wd;
        det_valid = dv; det_code = dc; steer_lvl = sl; tx_done = td;
        #1;
        if (!r)     exp_rd = 4'h0;
        else if (s) exp_rd = {sl, m_rxf, m_cb[0] && !m_txpend, m_irq};
        else        exp_rd = m_rxd;
        chk(r ? tag : "R10", "rdata", rdata, exp_rd);
        ev = td && m_txpend && m_cb[0];
        if (m_ca[2] && (dv || ev)) m_irq = 1;
        else if (r && s)           m_irq = 0;
        if (dv)     m_rxf = 1;
        else if (r) m_rxf = 0;
        if (dv) m_rxd = dc;
        m_txl = w && !s && m_ca[0];
        if (w && !s) begin m_txc = wd; m_txpend = 1; end
        else if (td) m_txpend = 0;
        if (w && s) begin
            if (!m_ptrb) begin m_ca = wd; m_ptrb = wd[3]; end
            else         begin m_cb = wd; m_ptrb = 0; end
        end
    endtask

    task automatic idle(); step(0,0,0,4'h0,0,4'h0,0,0,"R10"); endtask
    task automatic rd(input bit s, input bit sl, input string tag); step(s,1,0,4'h0,0,4'h0,sl,0,tag); endtask
    task automatic wr(input bit s, input logic [3:0] d, input string tag); step(s,0,1,d,0,4'h0,0,0,tag); endtask

    initial begin
        #(CLK_P*200000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1", "irq_n after reset", irq_n, 1);
        chk("R1", "tone_on after reset", tone_on, 0);
        chk("R1", "burst_en after reset", burst_en, 0);
        chk("R1", "tx_code after reset", tx_code, 0);
        rd(1, 0, "R1");                    // status reads 0
        rd(0, 0, "R1");                    // received digit 0
        // R6 control sequencing
        wr(1, 4'b1101, "R6");              // A: tone, irq_en, go to B
        wr(1, 4'b0011, "R6");              // B: burst, aux=001
        wr(1, 4'b0111, "R6");              // A again: tone, cp, irq_en
        wr(1, 4'b0101, "R6");              // still A (bank bit clear)
        idle();
        // R2 / R4 digit latch and status read
        step(0,0,0,4'h0,1,4'h9,0,0,"R2");
        idle();
        rd(1, 1, "R4");                    // 1111: steer, rxf, txe, irq
        rd(1, 0, "R4");                    // cleared: 0010
        // R3 data read clears full only
        step(0,0,0,4'h0,1,4'h5,0,0,"R3");
        rd(0, 0, "R3");                    // returns 5
        rd(0, 0, "R3");                    // digit retained
        rd(1, 0, "R3");                    // irq still set, rxf 0
        // R5 / R7 / R8 burst transmit
        wr(0, 4'hA, "R5");
        rd(1, 0, "R7");                    // txe 0
        step(0,0,0,4'h0,0,4'h0,0,1,"R7");  // burst done
        idle();
        rd(1, 0, "R7");                    // txe 1, irq 1
        // R9 collisions
        step(1,1,0,4'h0,1,4'h3,0,0,"R9");  // status read with new digit
        rd(1, 0, "R9");                    // irq and rxf still set
        wr(0, 4'h6, "R9");
        step(1,1,0,4'h0,0,4'h0,0,1,"R9");  // status read with burst end
        rd(1, 0, "R9");
        step(0,1,0,4'h0,1,4'hC,0,0,"R9");  // data read with new digit
        rd(0, 0, "R9");                    // returns C
        // R8 interrupt enable clear
        rd(1, 0, "R8");
        wr(1, 4'b0001, "R8");
        step(0,0,0,4'h0,1,4'h2,0,0,"R8");
        idle();
        rd(1, 0, "R8");                    // irq 0, rxf 1
        // R5 tone off blocks load pulse
        wr(1, 4'b0000, "R5");
        wr(0, 4'h7, "R5");
        idle();
        // R7 burst off masks transmit empty
        wr(1, 4'b1000, "R7");
        wr(1, 4'b0000, "R7");
        idle();
        rd(1, 0, "R7");
        // mixed traffic
        for (int i = 0; i < 600; i++) begin
            bit s, r, w, dv, sl, td;
            logic [3:0] d, c;
            s = 1'($urandom); r = ($urandom % 3) == 0; w = ($urandom % 4) == 0;
            dv = ($urandom % 5) == 0; sl = 1'($urandom); td = ($urandom % 4) == 0;
            d = 4'($urandom); c = 4'($urandom);
            step(s, r, w, d, dv, c, sl, td, s ? "R4" : "R2");
        end
        idle();
        idle();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule